// File: doc/BRIEF.md
# Wave-Ordered Memory Request Sequencer

This block sits between a dataflow execution fabric and a single memory port. The fabric produces loads and stores in whatever order their operands become ready. Each request carries a wave number and three ordering numbers: its own sequence number, the number of the request before it and the number of the request after it. Either neighbour field may be a wildcard when the compiler cannot know that neighbour. The sequencer parks requests in a small associative buffer and rebuilds program order one link at a time. It offers each request to memory only when that request's place in the chain is settled.

The chain state is the wave being drained, the sequence number of the last issued request and that request's successor field. A request that ends a wave moves the expected wave on by one and clears the chain to the wave-start state. Requests that belong to later waves wait in the buffer whenever they arrive. Load responses come back from memory in issue order. The block attaches the fabric's tag of the matching load to each response so that the value can be routed to its consumer.

Top module: `wom_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_valid` is 0 and `rsp_valid` is 0.
- R2: The buffer holds DEPTH (default 8) requests. `req_ready` is 0 exactly when DEPTH accepted requests are still waiting to issue, and it returns to 1 after requests issue.
- R3: After a request with a known successor field S (any value other than the wildcard 15) issues, the next request offered is the buffered request of the current wave whose sequence number is S.
- R4: After a request whose successor field is the wildcard (15) issues, the next request offered is the buffered request of the current wave whose predecessor field equals the last issued sequence number.
- R5: A request whose predecessor field is the wildcard (15) is offered as soon as the last issued request names its sequence number as successor.
- R6: Sequence number 0 is reserved as the start of every wave. At wave start the chain behaves as if sequence 0 had issued with a wildcard successor, so the first request of a wave carries predecessor 0.
- R7: Issuing a request whose `req_wave_end` flag was set advances the expected wave by one (modulo 16) and resets the chain to the wave-start state. Requests of any other wave are not offered, whatever their arrival order.
- R8: At most one request issues per cycle. While `mem_valid` is 1 and `mem_ready` is 0, the offered request stays unchanged. The chain advances only on a cycle where both are 1.
- R9: Each `mem_rsp_valid` pulse is passed through as `rsp_valid` with `rsp_data` equal to `mem_rsp_rdata` and `rsp_tag` equal to the tag of the oldest unanswered issued load. Stores take no tag.
- R10: With LD_DEPTH (default 4) loads issued and unanswered, a load that is next in order is held (`mem_valid` is 0) until a response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fabric request present |
| req_ready | output | 1 | Buffer can take a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_wave_end | input | 1 | Request is the last of its wave |
| req_wave | input | 4 | Wave number |
| req_pred | input | 4 | Predecessor sequence number, 15 = wildcard |
| req_seq | input | 4 | Own sequence number (1..14) |
| req_succ | input | 4 | Successor sequence number, 15 = wildcard |
| req_addr | input | 16 | Memory address |
| req_wdata | input | 16 | Store data |
| req_tag | input | 4 | Fabric tag returned with load data |
| mem_valid | output | 1 | Request offered to memory |
| mem_ready | input | 1 | Memory accepts the offered request |
| mem_store | output | 1 | Offered request is a store |
| mem_addr | output | 16 | Offered address |
| mem_wdata | output | 16 | Offered store data |
| mem_rsp_valid | input | 1 | Load data returning from memory |
| mem_rsp_rdata | input | 16 | Returned load data |
| rsp_valid | output | 1 | Load response to fabric |
| rsp_data | output | 16 | Load response data |
| rsp_tag | output | 4 | Tag of the answered load |

## Verification
On every cycle the assertions check that buffer occupancy, tracked from the two handshakes, stays within capacity and matches `req_ready`. They also check that a stalled offer stays stable, that a wave-ending issue steps the expected wave by one, that no load is offered beyond the outstanding-load limit, and that no response appears without an unanswered load. The actual chain order can only be shown by the bench's scenarios: known successors, wildcard successors and wildcard predecessors, requests from a later wave arriving first, and tags coming back in load order. Each of these needs the full stimulus history to predict.

// File: rtl/wom_pkg.sv
package wom_pkg;

    parameter int SEQ_W  = 4;
    parameter int WAVE_W = 4;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 16;
    parameter int TAG_W  = 4;

    localparam logic [SEQ_W-1:0] SEQ_WILD  = '1;
    localparam logic [SEQ_W-1:0] SEQ_START = '0;

    typedef struct packed {
        logic              is_store;
        logic              wave_end;
        logic [WAVE_W-1:0] wave;
        logic [SEQ_W-1:0]  pred;
        logic [SEQ_W-1:0]  seq;
        logic [SEQ_W-1:0]  succ;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [TAG_W-1:0]  tag;
    } mreq_t;

    typedef struct packed {
        logic [WAVE_W-1:0] wave;
        logic [SEQ_W-1:0]  last_seq;
        logic [SEQ_W-1:0]  last_succ;
    } chain_t;

    localparam chain_t CHAIN_INIT = '{wave: '0, last_seq: SEQ_START, last_succ: SEQ_WILD};

    // Does a buffered request sit directly after the chain's last issued request?
    function automatic logic wom_is_next(mreq_t e, chain_t c);
        if (e.wave != c.wave)
            return 1'b0;
        if (c.last_succ != SEQ_WILD)
            return e.seq == c.last_succ;
        return (e.pred != SEQ_WILD) && (e.pred == c.last_seq);
    endfunction

    // Chain state after request e issues.
    function automatic chain_t wom_chain_after(chain_t c, mreq_t e);
        chain_t n;
        if (e.wave_end) begin
            n.wave      = c.wave + 1'b1;
            n.last_seq  = SEQ_START;
            n.last_succ = SEQ_WILD;
        end else begin
            n.wave      = c.wave;
            n.last_seq  = e.seq;
            n.last_succ = e.succ;
        end
        return n;
    endfunction

endpackage

// File: rtl/wom_slot_buf.sv
module wom_slot_buf
    import wom_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  mreq_t            wr_ent,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output mreq_t            slot_ent [DEPTH],
    output logic [DEPTH-1:0] slot_vld,
    output logic             has_free
);

    logic [IDX_W-1:0] free_idx;

    // Lowest-numbered empty slot takes the next arrival.
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!slot_vld[i])
                free_idx = IDX_W'(i);
        end
    end

    assign has_free = ~&slot_vld;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic  vld_q;
        mreq_t ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= 1'b0;
            end else if (wr_en && has_free && free_idx == IDX_W'(g)) begin
                vld_q <= 1'b1;
                ent_q <= wr_ent;
            end else if (rd_en && rd_idx == IDX_W'(g)) begin
                vld_q <= 1'b0;
            end
        end

        assign slot_vld[g] = vld_q;
        assign slot_ent[g] = ent_q;
    end

endmodule

// File: rtl/wom_chain_ctl.sv
module wom_chain_ctl
    import wom_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  mreq_t             slot_ent [DEPTH],
    input  logic [DEPTH-1:0]  slot_vld,
    input  logic              adv,
    output logic              hit,
    output logic [IDX_W-1:0]  sel_idx,
    output mreq_t             sel_ent,
    output logic [WAVE_W-1:0] exp_wave
);

    chain_t           chain_q;
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign match[g] = slot_vld[g] && wom_is_next(slot_ent[g], chain_q);
    end

    // A well-formed stream has at most one match; the lowest index wins otherwise.
    always_comb begin
        sel_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i])
                sel_idx = IDX_W'(i);
        end
    end

    assign hit      = |match;
    assign sel_ent  = slot_ent[sel_idx];
    assign exp_wave = chain_q.wave;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= CHAIN_INIT;
        else if (adv)
            chain_q <= wom_chain_after(chain_q, sel_ent);
    end

endmodule

// File: rtl/wom_tag_fifo.sv
module wom_tag_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);

    logic [W-1:0]     store_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full    = count == CNT_W'(DEPTH);
    assign empty   = count == '0;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store_q[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                store_q[wr_ptr] <= push_data;
                wr_ptr          <= bump(wr_ptr);
            end
            if (do_pop)
                rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/wom_sequencer.sv
module wom_sequencer
    import wom_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int LD_DEPTH = 4,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic              req_wave_end,
    input  logic [WAVE_W-1:0] req_wave,
    input  logic [SEQ_W-1:0]  req_pred,
    input  logic [SEQ_W-1:0]  req_seq,
    input  logic [SEQ_W-1:0]  req_succ,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_store,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [TAG_W-1:0]  rsp_tag
);

    mreq_t             in_ent;
    mreq_t             slot_ent [DEPTH];
    logic [DEPTH-1:0]  slot_vld;
    logic              has_free;
    logic              hit;
    logic [IDX_W-1:0]  sel_idx;
    mreq_t             sel_ent;
    logic [WAVE_W-1:0] exp_wave;
    logic              ld_full, ld_empty;
    logic              fire;
    logic              sel_end;

    assign in_ent = '{is_store: req_store, wave_end: req_wave_end, wave: req_wave,
                      pred: req_pred, seq: req_seq, succ: req_succ,
                      addr: req_addr, wdata: req_wdata, tag: req_tag};

    assign req_ready = has_free;

    wom_slot_buf #(.DEPTH(DEPTH)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (req_valid),
        .wr_ent   (in_ent),
        .rd_en    (fire),
        .rd_idx   (sel_idx),
        .slot_ent (slot_ent),
        .slot_vld (slot_vld),
        .has_free (has_free)
    );

    wom_chain_ctl #(.DEPTH(DEPTH)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .slot_ent (slot_ent),
        .slot_vld (slot_vld),
        .adv      (fire),
        .hit      (hit),
        .sel_idx  (sel_idx),
        .sel_ent  (sel_ent),
        .exp_wave (exp_wave)
    );

    // A load may only go out while a tag slot is free for its response.
    assign mem_valid = hit && (sel_ent.is_store || !ld_full);
    assign fire      = mem_valid && mem_ready;
    assign mem_store = sel_ent.is_store;
    assign mem_addr  = sel_ent.addr;
    assign mem_wdata = sel_ent.wdata;
    assign sel_end   = sel_ent.wave_end;

    wom_tag_fifo #(.DEPTH(LD_DEPTH), .W(TAG_W)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .push      (fire && !sel_ent.is_store),
        .push_data (sel_ent.tag),
        .pop       (mem_rsp_valid),
        .head      (rsp_tag),
        .full      (ld_full),
        .empty     (ld_empty)
    );

    assign rsp_valid = mem_rsp_valid && !ld_empty;
    assign rsp_data  = mem_rsp_rdata;

endmodule

// File: rtl/wom_sequencer_chk.sv
module wom_sequencer_chk
    import wom_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int LD_DEPTH = 4,
    localparam int OCC_W   = $clog2(DEPTH + 1),
    localparam int OUT_W   = $clog2(LD_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_store,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              rsp_valid,
    input logic              issue_wave_end,
    input logic [WAVE_W-1:0] cur_wave
);

    logic [OCC_W-1:0] occ;
    logic [OUT_W-1:0] outst;
    logic             acc_in, acc_out, ld_out;

    assign acc_in  = req_valid && req_ready;
    assign acc_out = mem_valid && mem_ready;
    assign ld_out  = acc_out && !mem_store;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ   <= '0;
            outst <= '0;
        end else begin
            if (acc_in && !acc_out)
                occ <= occ + 1'b1;
            else if (acc_out && !acc_in)
                occ <= occ - 1'b1;
            if (ld_out && !rsp_valid)
                outst <= outst + 1'b1;
            else if (rsp_valid && !ld_out)
                outst <= outst - 1'b1;
        end
    end

    p_occ_bound_r2: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));

    p_ready_full_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready == (occ < OCC_W'(DEPTH)));

    p_offer_needs_entry_r3: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> occ != '0);

    p_wave_step_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && issue_wave_end) |=> cur_wave == WAVE_W'($past(cur_wave) + 1'b1));

    p_hold_offer_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_store) && $stable(mem_wdata));

    p_rsp_owed_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> outst != '0);

    p_load_cap_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_store) |-> outst < OUT_W'(LD_DEPTH));

endmodule

bind wom_sequencer wom_sequencer_chk #(.DEPTH(DEPTH), .LD_DEPTH(LD_DEPTH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .mem_valid      (mem_valid),
    .mem_ready      (mem_ready),
    .mem_store      (mem_store),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .rsp_valid      (rsp_valid),
    .issue_wave_end (sel_end),
    .cur_wave       (exp_wave)
);

// File: tb/tb_wom_sequencer.sv
`timescale 1ns/1ps
module tb_wom_sequencer;
    import wom_pkg::*;

    localparam int DEPTH    = 8;
    localparam int LD_DEPTH = 4;
    localparam int WILD     = 15;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_store = 1'b0;
    logic              req_wave_end = 1'b0;
    logic [WAVE_W-1:0] req_wave = '0;
    logic [SEQ_W-1:0]  req_pred = '0, req_seq = '0, req_succ = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              mem_valid;
    logic              mem_ready = 1'b0;
    logic              mem_store;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_rdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [TAG_W-1:0]  rsp_tag;

    always #2.5 clk = ~clk;

    wom_sequencer #(.DEPTH(DEPTH), .LD_DEPTH(LD_DEPTH)) dut (.*);

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int n_iss = 0;
    int n_rsp = 0;
    int iss_addr [64];
    int iss_cyc  [64];
    int rsp_tg   [16];
    int rsp_dt   [16];

    always @(posedge clk) cyc++;

    // Observe handshakes between edges.
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_valid && mem_ready) begin
                if (n_iss < 64) begin
                    iss_addr[n_iss] = int'(mem_addr);
                    iss_cyc[n_iss]  = cyc;
                end
                n_iss++;
            end
            if (rsp_valid) begin
                if (n_rsp < 16) begin
                    rsp_tg[n_rsp] = int'(rsp_tag);
                    rsp_dt[n_rsp] = int'(rsp_data);
                end
                n_rsp++;
            end
        end
    end

    task automatic check_eq(string rq, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic send(bit st, bit wend, int wave, int pred, int seq, int succ, int addr, int tag);
        @(posedge clk); #1;
        req_valid    = 1'b1;
        req_store    = st;
        req_wave_end = wend;
        req_wave     = WAVE_W'(wave);
        req_pred     = SEQ_W'(pred);
        req_seq      = SEQ_W'(seq);
        req_succ     = SEQ_W'(succ);
        req_addr     = ADDR_W'(addr);
        req_wdata    = DATA_W'(addr + 100);
        req_tag      = TAG_W'(tag);
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic respond(int data);
        @(posedge clk); #1;
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = DATA_W'(data);
        @(posedge clk); #1;
        mem_rsp_valid = 1'b0;
    endtask

    task automatic set_ready(bit v);
        @(posedge clk); #1;
        mem_ready = v;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_eq("R1", "req_ready after reset", int'(req_ready), 1);
        check_eq("R1", "mem_valid after reset", int'(mem_valid), 0);
        check_eq("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    endtask

    // R3 R6: known successors, arrival reversed, wave 0
    task automatic t_known();
        int base;
        set_ready(0);
        send(1, 1, 0, 2, 3, WILD, 3, 0);
        send(1, 0, 0, 1, 2, 3, 2, 0);
        send(1, 0, 0, 0, 1, 2, 1, 0);
        @(negedge clk);
        check_eq("R8", "offer waits for ready, first is pred 0", int'(mem_addr), 1);
        base = n_iss;
        set_ready(1);
        repeat (6) @(negedge clk);
        check_eq("R3", "issued count", n_iss - base, 3);
        for (int i = 0; i < 3; i++)
            check_eq("R3", $sformatf("order slot %0d", i), iss_addr[base + i], i + 1);
    endtask

    // R4 R5 R7: wildcard links; a later wave arrives first
    task automatic t_wild();
        int base;
        int exp_a [6] = '{10, 11, 12, 13, 14, 15};
        set_ready(0);
        send(1, 1, 2, 0, 1, WILD, 15, 0);
        send(1, 1, 1, 8, 9, WILD, 14, 0);
        send(1, 0, 1, WILD, 8, 9, 13, 0);
        send(1, 0, 1, 3, 7, 8, 12, 0);
        send(1, 0, 1, 2, 3, WILD, 11, 0);
        send(1, 0, 1, 0, 2, 3, 10, 0);
        base = n_iss;
        set_ready(1);
        repeat (10) @(negedge clk);
        check_eq("R7", "issued count across two waves", n_iss - base, 6);
        check_eq("R4", "after wildcard successor", iss_addr[base + 2], 12);
        check_eq("R5", "wildcard predecessor entry", iss_addr[base + 3], 13);
        check_eq("R7", "later wave issues last", iss_addr[base + 5], 15);
        for (int i = 0; i < 6; i++)
            check_eq("R4", $sformatf("order slot %0d", i), iss_addr[base + i], exp_a[i]);
    endtask

    // R8: stall holds offer; then one issue per cycle
    task automatic t_stall();
        int base;
        set_ready(0);
        send(1, 0, 3, 0, 1, 2, 20, 0);
        send(1, 1, 3, 1, 2, WILD, 21, 0);
        base = n_iss;
        @(negedge clk);
        check_eq("R8", "offer valid while stalled", int'(mem_valid), 1);
        repeat (3) @(negedge clk);
        check_eq("R8", "offer held", int'(mem_addr), 20);
        check_eq("R8", "no issue while stalled", n_iss - base, 0);
        set_ready(1);
        repeat (4) @(negedge clk);
        check_eq("R8", "both issued", n_iss - base, 2);
        check_eq("R8", "second issue one cycle later", iss_cyc[base + 1] - iss_cyc[base], 1);
        check_eq("R8", "second address", iss_addr[base + 1], 21);
    endtask

    // R2: fill the buffer, then drain in chain order
    task automatic t_full();
        int base;
        set_ready(0);
        for (int s = 8; s >= 1; s--)
            send(1, s == 8, 4, s - 1, s, (s == 8) ? WILD : s + 1, 30 + s, 0);
        @(negedge clk);
        check_eq("R2", "ready low when full", int'(req_ready), 0);
        base = n_iss;
        set_ready(1);
        repeat (12) @(negedge clk);
        check_eq("R2", "drained count", n_iss - base, 8);
        check_eq("R2", "ready back after drain", int'(req_ready), 1);
        for (int i = 0; i < 8; i++)
            check_eq("R3", $sformatf("full drain slot %0d", i), iss_addr[base + i], 31 + i);
    endtask

    // R9 R10: load tags in order; fifth load waits for a response
    task automatic t_loads();
        int base;
        int rbase;
        int exp_t [4] = '{3, 4, 5, 6};
        set_ready(1);
        base  = n_iss;
        rbase = n_rsp;
        send(0, 0, 5, 0, 1, 2, 40, 1);
        send(1, 0, 5, 1, 2, 3, 41, 2);
        send(0, 0, 5, 2, 3, 4, 42, 3);
        send(0, 0, 5, 3, 4, 5, 43, 4);
        send(0, 0, 5, 4, 5, 6, 44, 5);
        send(0, 1, 5, 5, 6, WILD, 45, 6);
        repeat (4) @(negedge clk);
        check_eq("R10", "issued before limit", n_iss - base, 5);
        check_eq("R10", "fifth load held", int'(mem_valid), 0);
        check_eq("R9", "no response from store", n_rsp - rbase, 0);
        respond(16'h77);
        check_eq("R9", "first response tag", rsp_tg[rbase], 1);
        check_eq("R9", "first response data", rsp_dt[rbase], 16'h77);
        repeat (3) @(negedge clk);
        check_eq("R10", "held load issues after response", n_iss - base, 6);
        check_eq("R10", "held load address", iss_addr[base + 5], 45);
        for (int i = 0; i < 4; i++)
            respond(16'h80 + i);
        @(negedge clk);
        check_eq("R9", "response count", n_rsp - rbase, 5);
        for (int i = 0; i < 4; i++) begin
            check_eq("R9", $sformatf("tag %0d", i + 1), rsp_tg[rbase + 1 + i], exp_t[i]);
            check_eq("R9", $sformatf("data %0d", i + 1), rsp_dt[rbase + 1 + i], 16'h80 + i);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_known();
        t_wild();
        t_stall();
        t_full();
        t_loads();
        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule